// File: doc/BRIEF.md
# Single-Address Accumulator Processor Core

This block is a small sequencing processor with one 16-bit accumulator. It reads its program from an external word-addressed memory. Each memory word holds one instruction or one data value. Every instruction names one memory operand. It can copy that operand into the accumulator, add the operand to the accumulator, or write the accumulator back to the operand's location.

The memory port has one read strobe, one write strobe, an address bus, a write-data bus and a read-data bus. A completion input tells the core when the memory has finished. The core raises a strobe and then holds it, along with the address and write data, for as long as the completion input stays low. Memory latency can therefore be any number of cycles.

An instruction passes through several internal registers in turn. Each step between registers takes its own cycle: the fetched word goes into a buffer register, and from there into the instruction register. If the core decodes an opcode it does not know, it halts and stays halted until the next reset.

Top module: `acc_core`

## Requirements
- R1: A synchronous active-high reset drops both strobes and `halted`, and clears the accumulator to zero. The first fetch after reset reads address 0.
- R2: A fetch raises `mem_rd` with `mem_addr` equal to the program counter. The word it returns is decoded as opcode bits [15:12] and operand address bits [11:0].
- R3: Once a strobe is raised, the strobe and `mem_addr` stay unchanged until the first clock edge at which `mem_done` is high. Read data is taken only at that edge.
- R4: The program counter advances by one for every fetched instruction and wraps from 0xFFF to 0x000.
- R5: Opcode 0000 reads the operand word and places it in the accumulator.
- R6: Opcode 1000 reads the operand word and adds it to the accumulator, modulo 2^16, with no carry kept.
- R7: Opcode 0001 raises `mem_wr` at the operand address and drives the accumulator on `mem_wdata`. That value holds steady until `mem_done`.
- R8: Any other opcode raises `halted`. After that there are no further memory accesses until reset.
- R9: Only one access is in flight at a time. The read and write strobes are never high together, and both are low in the cycle that follows a completed access.
- R10: A reset while an access is outstanding drops the strobe. Execution then restarts from address 0 with a cleared accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | ADDR_W | Word address of the current access |
| mem_rd | output | 1 | Read strobe, held until completion |
| mem_wr | output | 1 | Write strobe, held until completion |
| mem_wdata | output | DATA_W | Accumulator value being written |
| mem_rdata | input | DATA_W | Word returned by memory, valid with `mem_done` |
| mem_done | input | 1 | Memory-function-complete indication |
| halted | output | 1 | High once an unknown opcode has been decoded |

## Verification
The bench builds the core with its default sizes: 16-bit words and 12-bit addresses. Against a 4096-word memory model, a program of straight-line loads and adds can run the program counter through every address. This exercises the wrap from 0xFFF back to 0. The memory model draws completion latencies from zero cycles up to a long fixed wait. This covers both completion in the first waiting cycle and a reset that lands in the middle of a stalled fetch.

// File: rtl/acc_pkg.sv
package acc_pkg;

  typedef enum logic [2:0] {
    PH_FETCH,
    PH_FWAIT,
    PH_DECODE,
    PH_EXEC,
    PH_EWAIT,
    PH_HALT
  } phase_t;

  typedef enum logic [1:0] {
    K_LOAD,
    K_ADD,
    K_STORE,
    K_BAD
  } kind_t;

  localparam int OPC_W = 4;
  localparam logic [OPC_W-1:0] OPC_LOAD  = 4'b0000;
  localparam logic [OPC_W-1:0] OPC_ADD   = 4'b1000;
  localparam logic [OPC_W-1:0] OPC_STORE = 4'b0001;

endpackage

// File: rtl/acc_decode.sv
module acc_decode
  import acc_pkg::*;
(
  input  logic [OPC_W-1:0] opc,
  output kind_t            kind
);

  always_comb begin
    unique case (opc)
      OPC_LOAD:  kind = K_LOAD;
      OPC_ADD:   kind = K_ADD;
      OPC_STORE: kind = K_STORE;
      default:   kind = K_BAD;
    endcase
  end

endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
  import acc_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   mem_done,
  input  kind_t  kind,
  output phase_t phase,
  output logic   rd_q,
  output logic   wr_q,
  output logic   halt_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= PH_FETCH;
      rd_q   <= 1'b0;
      wr_q   <= 1'b0;
      halt_q <= 1'b0;
    end else begin
      unique case (phase)
        PH_FETCH: begin
          rd_q  <= 1'b1;
          phase <= PH_FWAIT;
        end
        PH_FWAIT: begin
          if (mem_done) begin
            rd_q  <= 1'b0;
            phase <= PH_DECODE;
          end
        end
        PH_DECODE: begin
          phase <= PH_EXEC;
        end
        PH_EXEC: begin
          unique case (kind)
            K_LOAD, K_ADD: begin
              rd_q  <= 1'b1;
              phase <= PH_EWAIT;
            end
            K_STORE: begin
              wr_q  <= 1'b1;
              phase <= PH_EWAIT;
            end
            default: begin
              halt_q <= 1'b1;
              phase  <= PH_HALT;
            end
          endcase
        end
        PH_EWAIT: begin
          if (mem_done) begin
            rd_q  <= 1'b0;
            wr_q  <= 1'b0;
            phase <= PH_FETCH;
          end
        end
        default: begin
          phase <= PH_HALT;
        end
      endcase
    end
  end

endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
  import acc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  phase_t             phase,
  input  kind_t              kind,
  input  logic               mem_done,
  input  logic [DATA_W-1:0]  mem_rdata,
  output logic [ADDR_W-1:0]  mar_q,
  output logic [DATA_W-1:0]  wdata_q,
  output logic [OPC_W-1:0]   opc
);

  logic [ADDR_W-1:0] pc_q;
  logic [DATA_W-1:0] mbr_q;
  logic [DATA_W-1:0] ir_q;
  logic [DATA_W-1:0] acc_q;

  assign opc = ir_q[DATA_W-1 -: OPC_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q    <= '0;
      mar_q   <= '0;
      mbr_q   <= '0;
      ir_q    <= '0;
      acc_q   <= '0;
      wdata_q <= '0;
    end else begin
      unique case (phase)
        PH_FETCH: mar_q <= pc_q;
        PH_FWAIT: begin
          if (mem_done) begin
            mbr_q <= mem_rdata;
            pc_q  <= pc_q + 1'b1;
          end
        end
        PH_DECODE: ir_q <= mbr_q;
        PH_EXEC: begin
          mar_q   <= ir_q[ADDR_W-1:0];
          wdata_q <= acc_q;
        end
        PH_EWAIT: begin
          if (mem_done) begin
            if (kind == K_LOAD) acc_q <= mem_rdata;
            else if (kind == K_ADD) acc_q <= acc_q + mem_rdata;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_done,
  output logic              halted
);

  phase_t           phase;
  kind_t            kind;
  logic [OPC_W-1:0] opc;

  acc_decode u_dec (
    .opc  (opc),
    .kind (kind)
  );

  acc_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .mem_done (mem_done),
    .kind     (kind),
    .phase    (phase),
    .rd_q     (mem_rd),
    .wr_q     (mem_wr),
    .halt_q   (halted)
  );

  acc_datapath #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .phase     (phase),
    .kind      (kind),
    .mem_done  (mem_done),
    .mem_rdata (mem_rdata),
    .mar_q     (mem_addr),
    .wdata_q   (mem_wdata),
    .opc       (opc)
  );

endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_done,
  input logic              halted
);

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (!mem_rd && !mem_wr && !halted)); // R1

  AST_RD_HELD: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && !mem_done) |=> mem_rd); // R3

  AST_WR_HELD: assert property (@(posedge clk) disable iff (rst)
    (mem_wr && !mem_done) |=> mem_wr); // R3

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
    ((mem_rd || mem_wr) && !mem_done) |=> $stable(mem_addr)); // R3

  AST_WDATA_STABLE: assert property (@(posedge clk) disable iff (rst)
    (mem_wr && !mem_done) |=> $stable(mem_wdata)); // R7

  AST_HALT_SILENT: assert property (@(posedge clk) disable iff (rst)
    halted |-> (!mem_rd && !mem_wr)); // R8

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted); // R8

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_rd, mem_wr})); // R9

  AST_GAP_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    ((mem_rd || mem_wr) && mem_done) |=> (!mem_rd && !mem_wr)); // R9

endmodule

bind acc_core acc_core_chk #(
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W)
) i_chk (
  .clk       (clk),
  .rst       (rst),
  .mem_addr  (mem_addr),
  .mem_rd    (mem_rd),
  .mem_wr    (mem_wr),
  .mem_wdata (mem_wdata),
  .mem_done  (mem_done),
  .halted    (halted)
);

// File: tb/test_acc_core.sv
module test_acc_core;

  localparam int DW = 16;
  localparam int AW = 12;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] mem_addr;
  logic          mem_rd, mem_wr, halted;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata = '0;
  logic          mem_done = 1'b0;

  always #5 clk = ~clk;

  acc_core #(.DATA_W(DW), .ADDR_W(AW)) i_acc_core (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_done(mem_done), .halted(halted)
  );

  logic [DW-1:0] mem [DEPTH];
  int n_chk = 0;
  int n_bad = 0;
  int lat_mode = 1;

  // reference state
  logic [AW-1:0] ref_pc;
  logic [DW-1:0] ref_acc;
  bit            ref_oper;
  logic [3:0]    ref_op;
  logic [AW-1:0] ref_oaddr;
  bit            ref_halt;
  int            fetches;
  bit            last_top;
  bit            wrap_seen;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit legal(input logic [3:0] op);
    return (op == 4'b0000) || (op == 4'b1000) || (op == 4'b0001);
  endfunction

  function automatic logic [DW-1:0] add16(input logic [DW-1:0] a, input logic [DW-1:0] b);
    logic [DW:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[DW-1:0];
  endfunction

  task automatic ref_reset();
    ref_pc = '0; ref_acc = '0; ref_oper = 0; ref_op = '0; ref_oaddr = '0;
    ref_halt = 0; fetches = 0; last_top = 0; wrap_seen = 0;
  endtask

  task automatic ref_txn(input bit is_wr, input logic [AW-1:0] a, input logic [DW-1:0] wd);
    logic [DW-1:0] w;
    if (ref_halt) begin
      check(0, "R8", "access after halt", a, 0);
      return;
    end
    if (!ref_oper) begin
      check(!is_wr, "R2", "fetch kind is read", is_wr, 0);
      check(a == ref_pc, "R4", "fetch address", a, ref_pc);
      if (last_top && a == '0) wrap_seen = 1;
      last_top = (a == {AW{1'b1}});
      w = mem[a];
      fetches++;
      ref_pc = ref_pc + 1'b1;
      ref_op = w[15:12];
      ref_oaddr = w[AW-1:0];
      if (legal(ref_op)) ref_oper = 1;
      else ref_halt = 1;
    end else begin
      check(is_wr == (ref_op == 4'b0001), "R2", "operand access kind", is_wr, ref_op == 4'b0001);
      check(a == ref_oaddr, "R2", "operand address", a, ref_oaddr);
      if (ref_op == 4'b0000) ref_acc = mem[a];
      else if (ref_op == 4'b1000) ref_acc = add16(ref_acc, mem[a]);
      else begin
        check(wd == ref_acc, "R7", "store data", wd, ref_acc);
        mem[a] = wd;
      end
      ref_oper = 0;
    end
  endtask

  // memory model with completion handshake
  bit            pend = 0;
  int            cnt = 0;
  logic [AW-1:0] seen_addr;

  always @(negedge clk) begin
    if (rst) begin
      mem_done = 1'b0;
      pend = 0;
      cnt = 0;
    end else if (mem_done) begin
      mem_done = 1'b0;
    end else if (mem_rd || mem_wr) begin
      if (!pend) begin
        pend = 1;
        seen_addr = mem_addr;
        cnt = (lat_mode == 0) ? 0 : (lat_mode == 2) ? 30 : int'($urandom_range(5, 0));
      end
      if (mem_addr != seen_addr) check(0, "R3", "address moved while waiting", mem_addr, seen_addr);
      if (cnt == 0) begin
        if (mem_rd) mem_rdata = mem[mem_addr];
        ref_txn(mem_wr, mem_addr, mem_wdata);
        mem_done = 1'b1;
        pend = 0;
      end else begin
        cnt--;
      end
    end else if (pend) begin
      check(0, "R3", "strobe dropped before completion", 0, 1);
      pend = 0;
    end
  end

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    ref_reset();
  endtask

  task automatic run_to_halt(input int lim);
    for (int i = 0; i < lim; i++) begin
      if (halted) break;
      @(negedge clk);
    end
  endtask

  function automatic logic [DW-1:0] ins(input logic [3:0] op, input logic [AW-1:0] a);
    return {op, a};
  endfunction

  function automatic logic [3:0] bad_op();
    logic [3:0] o;
    o = 4'($urandom_range(15, 0));
    while (legal(o)) o = 4'($urandom_range(15, 0));
    return o;
  endfunction

  initial begin
    #1500000;
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
    ref_reset();

    // directed: load, add with wrap, halt
    mem[0] = ins(4'b0000, 12'h200);
    mem[1] = ins(4'b0001, 12'h300);
    mem[2] = ins(4'b1000, 12'h201);
    mem[3] = ins(4'b0001, 12'h301);
    mem[4] = ins(4'b0000, 12'h202);
    mem[5] = ins(4'b1000, 12'h202);
    mem[6] = ins(4'b0001, 12'h302);
    mem[7] = 16'hF000;
    mem[12'h200] = 16'h1234;
    mem[12'h201] = 16'hFFFF;
    mem[12'h202] = 16'h8000;
    lat_mode = 1;
    do_reset();
    check(!mem_rd && !mem_wr, "R1", "strobes in reset", {mem_rd, mem_wr}, 0);
    check(!halted, "R1", "halted in reset", halted, 0);
    rst = 1'b0;
    run_to_halt(2000);
    check(mem[12'h300] == 16'h1234, "R5", "load result", mem[12'h300], 16'h1234);
    check(mem[12'h301] == 16'h1233, "R6", "add wraps", mem[12'h301], 16'h1233);
    check(mem[12'h302] == 16'h0000, "R6", "0x8000+0x8000", mem[12'h302], 0);
    check(halted, "R8", "halted after bad opcode", halted, 1);
    check(fetches == 8, "R8", "fetch count", fetches, 8);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (mem_rd || mem_wr) check(0, "R8", "strobe while halted", {mem_rd, mem_wr}, 0);
    end

    // reset during a stalled fetch
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
    mem[0] = ins(4'b0001, 12'h310);
    mem[1] = 16'hA000;
    mem[12'h310] = 16'hBEEF;
    lat_mode = 2;
    do_reset();
    rst = 1'b0;
    repeat (6) @(negedge clk);
    check(mem_rd, "R3", "read held during long wait", mem_rd, 1);
    rst = 1'b1;
    @(negedge clk);
    ref_reset();
    check(!mem_rd && !mem_wr, "R10", "strobe dropped by reset", {mem_rd, mem_wr}, 0);
    @(negedge clk);
    rst = 1'b0;
    lat_mode = 1;
    run_to_halt(2000);
    check(mem[12'h310] == 16'h0000, "R10", "accumulator cleared after abort", mem[12'h310], 0);
    check(halted && fetches == 2, "R1", "restart from address 0", fetches, 2);

    // random program
    for (int i = 0; i < DEPTH; i++) mem[i] = DW'($urandom);
    for (int i = 0; i < 300; i++) begin
      int k;
      k = int'($urandom_range(9, 0));
      if (k < 3) mem[i] = ins(4'b0000, {4'hC, 8'($urandom)});
      else if (k < 7) mem[i] = ins(4'b1000, {4'hC, 8'($urandom)});
      else mem[i] = ins(4'b0001, {4'hD, 8'($urandom)});
    end
    mem[300] = {bad_op(), 12'h000};
    do_reset();
    rst = 1'b0;
    run_to_halt(20000);
    check(halted, "R8", "random program halted", halted, 1);
    check(fetches == 301, "R8", "random fetch count", fetches, 301);

    // counter wrap with zero-latency memory
    for (int i = 0; i < DEPTH; i++) begin
      if (i % 200 == 199) mem[i] = ins(4'b0001, AW'(i - 1));
      else mem[i] = ins($urandom_range(1, 0) ? 4'b1000 : 4'b0000, AW'($urandom));
    end
    lat_mode = 0;
    do_reset();
    rst = 1'b0;
    for (int i = 0; i < 40000; i++) begin
      if (wrap_seen || halted) break;
      @(negedge clk);
    end
    check(wrap_seen, "R4", "pc wraps to 0 after 0xFFF", wrap_seen, 1);
    check(!halted, "R4", "no halt during wrap run", halted, 0);
    do_reset();
    check(!mem_rd && !mem_wr && !halted, "R1", "outputs after final reset", {mem_rd, mem_wr, halted}, 0);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule